// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steers a processor core between four power modes: Active, Power Save, Idle and Halt. Software asks for a lower-power mode by writing a small control register while the core is in Active. A request either takes effect on the next clock or waits until the core raises a wait-for-interrupt strobe. Any hardware wake-up brings the core back to Active. A wake-up can come from one of several maskable sources or from a non-maskable interrupt. It is caught in a sticky latch, and the latch holds it until the interrupt controller acknowledges it.

Three clock-health inputs gate the mode changes. A low-frequency oscillator that is not stable blocks every entry into a lower-power mode. A main oscillator that is not stable, or a PLL that is powered but not locked, holds the core in its low-power mode until both clocks are ready. The same three health flags can be read in a status byte. A PLL that is switched off reports as healthy, so it never stalls a transition. All pins are plain control and status signals, so there is no handshake and no back-pressure at the edge of the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode is Active, the control register reads 0 and no wake-up is pending.
- R2: The control register layout is bit 0 for the power-save request, bit 1 for the idle request, bit 2 for the halt request and bit 3 for the wait-first flag. Bits 7:4 always read 0. A write is accepted only in Active, only with at most one of bits 2:0 set, and only with bits 7:4 clear. Any other write leaves the register unchanged.
- R3: In Active, a power-save request with the wait-first flag clear gives mode Power Save at the clock edge after the edge that loads the request.
- R4: With the wait-first flag set, a power-save request waits for the wait strobe. Idle and halt requests always wait for the strobe. The mode changes at the edge where the strobe is sampled high.
- R5: While the low-frequency oscillator is not stable, the block does not leave Active.
- R6: Any maskable source or the NMI sets the pending flag at the next edge. The flag stays set until an acknowledge is sampled. If an event and an acknowledge arrive in the same cycle, the flag stays set.
- R7: In Power Save, Idle or Halt, the block returns to Active at the edge where the pending flag is 1 and both the main-clock and PLL-clock flags are good.
- R8: While the main oscillator is unstable, or the PLL is enabled but unlocked, the block stays in its current low-power mode.
- R9: The status byte reads {5'b0, pll_good, main_stable, lf_stable}, where pll_good = !pll_enable | pll_locked. It follows the inputs without delay.
- R10: The return to Active clears request bits 2:0 and keeps the wait-first flag.
- R11: While a wake-up is pending, the block does not leave Active.
- R12: The mode output is encoded as 00 for Active, 01 for Power Save, 10 for Idle and 11 for Halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| ctrl_rd | output | 8 | Control register readback |
| status_rd | output | 8 | Clock-health status byte |
| wfi_strobe | input | 1 | Wait-for-interrupt strobe from the core |
| wake_src | input | 4 | Maskable wake-up sources |
| wake_nmi | input | 1 | Non-maskable wake-up |
| irq_ack | input | 1 | Interrupt acknowledge, clears the pending flag |
| lf_stable | input | 1 | Low-frequency oscillator stable |
| main_stable | input | 1 | Main oscillator stable |
| pll_enable | input | 1 | PLL powered |
| pll_locked | input | 1 | PLL locked |
| mode | output | 2 | Current power mode |
| wake_pending | output | 1 | Latched wake-up flag |

## Verification
If the mode register holds a wrong value, the mode output shows it in the same cycle. That wrong mode also changes which writes are accepted, so the register readback differs from the expected value within one further write. A wrong pending flag shows at its own pin at once. One cycle later it also shows as a return to Active that comes too early or never comes. Every cycle, the bench compares the mode, the register readback and the pending flag with a cycle-level model, so a divergence is reported in the cycle where it first appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_SAVE   = 2'b01,
    PM_IDLE   = 2'b10,
    PM_HALT   = 2'b11
  } pm_mode_e;

  localparam int CTRL_BITS = 4;

  typedef struct packed {
    logic waitb;
    logic halt;
    logic idle;
    logic save;
  } pm_ctrl_t;
endpackage

// File: rtl/pmc_clk_qual.sv
module pmc_clk_qual #(
  parameter int REG_W = 8
) (
  input  logic             lf_ok_i,
  input  logic             main_ok_i,
  input  logic             pll_en_i,
  input  logic             pll_lock_i,
  output logic             enter_ok_o,
  output logic             resume_ok_o,
  output logic [REG_W-1:0] status_o
);
  logic pll_good;

  assign pll_good    = !pll_en_i || pll_lock_i;
  assign enter_ok_o  = lf_ok_i;
  assign resume_ok_o = main_ok_i && pll_good;

  always_comb begin
    status_o    = '0;
    status_o[0] = lf_ok_i;
    status_o[1] = main_ok_i;
    status_o[2] = pll_good;
  end
endmodule

// File: rtl/pmc_wake_latch.sv
module pmc_wake_latch #(
  parameter int WAKE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_W-1:0] src_i,
  input  logic              nmi_i,
  input  logic              ack_i,
  output logic              pending_o
);
  logic any_evt;

  assign any_evt = (|src_i) || nmi_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       pending_o <= 1'b0;
    else if (any_evt) pending_o <= 1'b1;
    else if (ack_i)   pending_o <= 1'b0;
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> pending_o); // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !ack_i) |=> pending_o); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !any_evt) |=> !pending_o); // R6
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             in_active_i,
  input  logic             clr_req_i,
  output pm_ctrl_t         ctrl_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int UPPER_W = REG_W - CTRL_BITS;

  pm_ctrl_t wr_val;
  logic     wr_legal;
  logic     wr_take;

  assign wr_val   = pm_ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
  assign wr_legal = (wr_data_i[REG_W-1:CTRL_BITS] == '0) &&
                    ($countones({wr_val.halt, wr_val.idle, wr_val.save}) <= 1);
  assign wr_take  = wr_en_i && in_active_i && wr_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_take) begin
      ctrl_o <= wr_val;
    end else if (clr_req_i) begin
      ctrl_o.save <= 1'b0;
      ctrl_o.idle <= 1'b0;
      ctrl_o.halt <= 1'b0;
    end
  end

  assign rd_data_o = {{UPPER_W{1'b0}}, ctrl_o};

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_o.halt, ctrl_o.idle, ctrl_o.save}) <= 1); // R2
  AST_LOWPWR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_active_i && !clr_req_i) |=> $stable(ctrl_o)); // R2
  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req_i |=> (!ctrl_o.save && !ctrl_o.idle && !ctrl_o.halt &&
                   ctrl_o.waitb == $past(ctrl_o.waitb))); // R10
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_ctrl_t ctrl_i,
  input  logic     wfi_i,
  input  logic     pending_i,
  input  logic     enter_ok_i,
  input  logic     resume_ok_i,
  output pm_mode_e mode_o,
  output logic     clr_req_o
);
  pm_mode_e mode_nx;
  logic     may_enter;

  assign may_enter = enter_ok_i && !pending_i;
  assign clr_req_o = (mode_o != PM_ACTIVE) && pending_i && resume_ok_i;

  always_comb begin
    mode_nx = mode_o;
    case (mode_o)
      PM_ACTIVE: begin
        if (may_enter) begin
          if (ctrl_i.save && (!ctrl_i.waitb || wfi_i)) mode_nx = PM_SAVE;
          else if (ctrl_i.idle && wfi_i)               mode_nx = PM_IDLE;
          else if (ctrl_i.halt && wfi_i)               mode_nx = PM_HALT;
        end
      end
      default: begin
        if (clr_req_o) mode_nx = PM_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_o <= PM_ACTIVE;
    else        mode_o <= mode_nx;
  end

  AST_LF_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_ACTIVE && !enter_ok_i) |=> mode_o == PM_ACTIVE); // R5
  AST_PENDING_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_ACTIVE && pending_i) |=> mode_o == PM_ACTIVE); // R11
  AST_WAIT_FOR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_ACTIVE && !wfi_i && !(ctrl_i.save && !ctrl_i.waitb))
      |=> mode_o == PM_ACTIVE); // R4
  AST_CLOCKS_BLOCK_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != PM_ACTIVE && !resume_ok_i) |=> $stable(mode_o)); // R8
  AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != PM_ACTIVE && pending_i && resume_ok_i) |=> mode_o == PM_ACTIVE); // R7
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int WAKE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  ctrl_rd,
  output logic [REG_W-1:0]  status_rd,
  input  logic              wfi_strobe,
  input  logic [WAKE_W-1:0] wake_src,
  input  logic              wake_nmi,
  input  logic              irq_ack,
  input  logic              lf_stable,
  input  logic              main_stable,
  input  logic              pll_enable,
  input  logic              pll_locked,
  output logic [1:0]        mode,
  output logic              wake_pending
);
  pm_ctrl_t ctrl;
  pm_mode_e mode_q;
  logic     enter_ok;
  logic     resume_ok;
  logic     clr_req;

  pmc_clk_qual #(.REG_W(REG_W)) u_qual (
    .lf_ok_i    (lf_stable),
    .main_ok_i  (main_stable),
    .pll_en_i   (pll_enable),
    .pll_lock_i (pll_locked),
    .enter_ok_o (enter_ok),
    .resume_ok_o(resume_ok),
    .status_o   (status_rd)
  );

  pmc_wake_latch #(.WAKE_W(WAKE_W)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (wake_src),
    .nmi_i    (wake_nmi),
    .ack_i    (irq_ack),
    .pending_o(wake_pending)
  );

  pmc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr_en),
    .wr_data_i  (reg_wr_data),
    .in_active_i(mode_q == PM_ACTIVE),
    .clr_req_i  (clr_req),
    .ctrl_o     (ctrl),
    .rd_data_o  (ctrl_rd)
  );

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_i     (ctrl),
    .wfi_i      (wfi_strobe),
    .pending_i  (wake_pending),
    .enter_ok_i (enter_ok),
    .resume_ok_i(resume_ok),
    .mode_o     (mode_q),
    .clr_req_o  (clr_req)
  );

  assign mode = mode_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (mode == 2'b00 && ctrl_rd == '0 && !wake_pending)); // R1
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] ctrl_rd, status_rd;
  logic       wfi_strobe = 1'b0;
  logic [3:0] wake_src = '0;
  logic       wake_nmi = 1'b0;
  logic       irq_ack = 1'b0;
  logic       lf_stable = 1'b1;
  logic       main_stable = 1'b1;
  logic       pll_enable = 1'b0;
  logic       pll_locked = 1'b0;
  logic [1:0] mode;
  logic       wake_pending;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (.*);

  // Cycle model built from the requirements
  logic [1:0] m_mode = 2'b00;
  logic [3:0] m_ctrl = 4'h0;
  logic       m_pend = 1'b0;
  logic [1:0] nm;
  logic [3:0] nc;
  logic       rok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 2'b00; m_ctrl = 4'h0; m_pend = 1'b0;
    end else begin
      rok = main_stable && (!pll_enable || pll_locked);
      nm = m_mode;
      if (m_mode == 2'b00) begin
        if (lf_stable && !m_pend) begin
          if (m_ctrl[0] && (!m_ctrl[3] || wfi_strobe)) nm = 2'b01;
          else if (m_ctrl[1] && wfi_strobe)            nm = 2'b10;
          else if (m_ctrl[2] && wfi_strobe)            nm = 2'b11;
        end
      end else if (m_pend && rok) nm = 2'b00;
      nc = m_ctrl;
      if (m_mode == 2'b00 && reg_wr_en && reg_wr_data[7:4] == 4'h0 &&
          $countones(reg_wr_data[2:0]) <= 1)
        nc = reg_wr_data[3:0];
      else if (m_mode != 2'b00 && m_pend && rok)
        nc = {m_ctrl[3], 3'b000};
      m_pend = ((|wake_src) || wake_nmi) ? 1'b1 : (irq_ack ? 1'b0 : m_pend);
      m_mode = nm;
      m_ctrl = nc;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R12/R3/R4/R7 model mode", {6'b0, mode}, {6'b0, m_mode});
      check("R2/R10 model ctrl", ctrl_rd, {4'h0, m_ctrl});
      check("R6 model pending", {7'b0, wake_pending}, {7'b0, m_pend});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d; tick(); reg_wr_en = 1'b0;
  endtask

  task automatic wfi_pulse();
    wfi_strobe = 1'b1; tick(); wfi_strobe = 1'b0;
  endtask

  task automatic nmi_pulse();
    wake_nmi = 1'b1; tick(); wake_nmi = 1'b0;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    check("R1 mode", {6'b0, mode}, 8'h00);
    check("R1 ctrl", ctrl_rd, 8'h00);
    check("R1 pending", {7'b0, wake_pending}, 8'h00);

    // R9 status byte
    check("R9 pll off", status_rd, 8'h07);
    pll_enable = 1'b1; #1 check("R9 pll unlocked", status_rd, 8'h03);
    pll_locked = 1'b1; #1 check("R9 pll locked", status_rd, 8'h07);
    lf_stable = 1'b0; main_stable = 1'b0; #1 check("R9 osc down", status_rd, 8'h04);
    lf_stable = 1'b1; main_stable = 1'b1; pll_enable = 1'b0; pll_locked = 1'b0;

    // R2 illegal writes
    wr(8'h03); check("R2 two requests ignored", ctrl_rd, 8'h00);
    wr(8'h11); check("R2 upper bits ignored", ctrl_rd, 8'h00);

    // R5 then R3
    lf_stable = 1'b0;
    wr(8'h01); check("R2 legal write", ctrl_rd, 8'h01);
    tick(); tick(); check("R5 lf unstable stays active", {6'b0, mode}, 8'h00);
    lf_stable = 1'b1;
    tick(); check("R3 power save entered", {6'b0, mode}, 8'h01);
    wr(8'h04); check("R2 write ignored in low power", ctrl_rd, 8'h01);

    // R8 / R7 / R10
    main_stable = 1'b0;
    nmi_pulse(); check("R6 nmi latched", {7'b0, wake_pending}, 8'h01);
    tick(); tick(); check("R8 main unstable holds", {6'b0, mode}, 8'h01);
    main_stable = 1'b1; pll_enable = 1'b1;
    tick(); check("R8 pll unlocked holds", {6'b0, mode}, 8'h01);
    pll_locked = 1'b1;
    tick(); check("R7 return to active", {6'b0, mode}, 8'h00);
    check("R10 requests cleared", ctrl_rd, 8'h00);

    // R6 latch behaviour
    tick(); check("R6 held", {7'b0, wake_pending}, 8'h01);
    wake_src = 4'h1; irq_ack = 1'b1; tick(); wake_src = '0;
    check("R6 set wins over ack", {7'b0, wake_pending}, 8'h01);
    tick(); irq_ack = 1'b0;
    check("R6 ack clears", {7'b0, wake_pending}, 8'h00);

    // R11
    nmi_pulse();
    wr(8'h01); tick(); check("R11 pending blocks entry", {6'b0, mode}, 8'h00);
    ack_pulse(); check("R11 still active at ack edge", {6'b0, mode}, 8'h00);
    tick(); check("R3 entry after ack", {6'b0, mode}, 8'h01);
    nmi_pulse(); tick(); check("R7 back", {6'b0, mode}, 8'h00);
    ack_pulse();

    // R4 wait-first power save
    wr(8'h09); tick(); tick();
    check("R4 waits for strobe", {6'b0, mode}, 8'h00);
    wfi_pulse(); check("R4 entered on strobe", {6'b0, mode}, 8'h01);
    wake_src = 4'h2; tick(); wake_src = '0; tick();
    check("R10 wait flag kept", ctrl_rd, 8'h08);
    ack_pulse();

    // Idle and Halt
    wr(8'h02); tick(); check("R4 idle waits", {6'b0, mode}, 8'h00);
    wfi_pulse(); check("R12 idle code", {6'b0, mode}, 8'h02);
    nmi_pulse(); tick(); ack_pulse();
    wr(8'h0C); wfi_pulse(); check("R12 halt code", {6'b0, mode}, 8'h03);
    nmi_pulse(); tick(); check("R7 halt exit", {6'b0, mode}, 8'h00);
    ack_pulse();

    // Constrained random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      reg_wr_en   = ($urandom % 4) == 0;
      reg_wr_data = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 16);
      wfi_strobe  = ($urandom % 6) == 0;
      wake_src    = (($urandom % 20) == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      wake_nmi    = ($urandom % 40) == 0;
      irq_ack     = ($urandom % 8) == 0;
      lf_stable   = ($urandom % 8) != 0;
      main_stable = ($urandom % 8) != 0;
      pll_enable  = ($urandom % 2) == 0;
      pll_locked  = ($urandom % 4) != 0;
      #1 check("R9 random status", status_rd,
               {5'b0, (!pll_enable || pll_locked), main_stable, lf_stable});
    end
    @(negedge clk);
    finish_run();
  end
endmodule